// File: doc/BRIEF.md
# FIFO Configuration Lock Register

This block holds the FIFO settings of a floppy disk controller: a FIFO disable flag, a 4-bit FIFO threshold and an 8-bit track number from which write precompensation starts. A configuration write loads all three settings at once. A separate lock write sets a lock flag. The lock flag decides whether a software reset, which comes from the controller's control registers, puts the three settings back to their defaults.

A hardware reset always clears the lock flag and restores every default. A software reset never changes the lock flag. Each lock write returns one status byte on the following cycle, and that byte echoes the lock value just written. The lock has no effect on configuration writes: the FIFO can be disabled through a configuration write whether the block is locked or not.

The defaults are: FIFO disabled (disable flag 1), threshold 0, start track 0.

Top module: `fifo_cfg_lock`

## Requirements
- R1: While `hw_rst` is high, the outputs are `lock`=0, `fifo_dis`=1, `fifo_thr`=0, `pre_trk`=0, `stat_vld`=0 and `stat_byte`=0.
- R2: A configuration write (`cfg_we`=1) loads `cfg_dis`, `cfg_thr` and `cfg_trk` into `fifo_dis`, `fifo_thr` and `pre_trk` on the next cycle, whether `lock` is 0 or 1.
- R3: A software reset (`sw_rst`=1) while `lock`=0 restores `fifo_dis`=1, `fifo_thr`=0 and `pre_trk`=0 on the next cycle.
- R4: A software reset while `lock`=1 leaves `fifo_dis`, `fifo_thr` and `pre_trk` unchanged.
- R5: A software reset never changes `lock`.
- R6: A lock write (`lock_we`=1) sets `lock` to `lock_val` on the next cycle.
- R7: One cycle after a lock write, `stat_vld` is high for exactly one cycle. At that point `stat_byte` bit 4 equals the `lock_val` of that write and bits 7..5 and 3..0 are 0. `stat_vld` is low in every cycle that does not follow a lock write.
- R8: When `cfg_we` and `sw_rst` are high in the same cycle, the configuration write takes effect over the software reset.
- R9: When `lock_we` and `sw_rst` are high in the same cycle, the software reset acts according to the lock value held before that cycle.
- R10: A hardware reset takes effect over any configuration write, lock write or software reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, active high, asynchronous |
| sw_rst | input | 1 | Software reset strobe from the control registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dis | input | 1 | New FIFO disable flag |
| cfg_thr | input | 4 | New FIFO threshold |
| cfg_trk | input | 8 | New precompensation start track |
| lock_we | input | 1 | Lock write strobe |
| lock_val | input | 1 | New lock value |
| fifo_dis | output | 1 | Current FIFO disable flag |
| fifo_thr | output | 4 | Current FIFO threshold |
| pre_trk | output | 8 | Current precompensation start track |
| lock | output | 1 | Current lock flag |
| stat_vld | output | 1 | Status byte valid, one-cycle pulse |
| stat_byte | output | 8 | Status byte returned for a lock write |

## Verification
Every synchronous result appears one clock edge after the stimulus that causes it. This holds for loaded settings, restored defaults, the lock flag and the status pulse. A hardware reset acts as soon as it is asserted. The driver applies each stimulus on a falling edge and queues the expected outputs for the following rising edge. The monitor pops that entry two time units after the rising edge, so each comparison lands in the exact cycle the result is due. Cycles in which nothing should change are queued as well, so stray updates and stretched status pulses are caught.

// File: rtl/fifo_cfg_lock.sv
module fifo_cfg_lock #(
  parameter int THR_W    = 4,
  parameter int TRK_W    = 8,
  parameter int STAT_W   = 8,
  parameter int LOCK_BIT = 4
) (
  input  logic             clk,
  input  logic             hw_rst,
  input  logic             sw_rst,
  input  logic             cfg_we,
  input  logic             cfg_dis,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic [TRK_W-1:0] cfg_trk,
  input  logic             lock_we,
  input  logic             lock_val,
  output logic             fifo_dis,
  output logic [THR_W-1:0] fifo_thr,
  output logic [TRK_W-1:0] pre_trk,
  output logic             lock,
  output logic             stat_vld,
  output logic [STAT_W-1:0] stat_byte
);

  localparam logic [THR_W-1:0] THR_DEF = '0;
  localparam logic [TRK_W-1:0] TRK_DEF = '0;

  logic restore;
  assign restore = sw_rst && !lock;

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst) begin
      fifo_dis <= 1'b1;
      fifo_thr <= THR_DEF;
      pre_trk  <= TRK_DEF;
    end else if (cfg_we) begin
      fifo_dis <= cfg_dis;
      fifo_thr <= cfg_thr;
      pre_trk  <= cfg_trk;
    end else if (restore) begin
      fifo_dis <= 1'b1;
      fifo_thr <= THR_DEF;
      pre_trk  <= TRK_DEF;
    end
  end

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst) begin
      lock      <= 1'b0;
      stat_vld  <= 1'b0;
      stat_byte <= '0;
    end else begin
      stat_vld <= lock_we;
      if (lock_we) begin
        lock      <= lock_val;
        stat_byte <= STAT_W'(lock_val) << LOCK_BIT;
      end
    end
  end

endmodule

module fifo_cfg_lock_chk #(
  parameter int THR_W    = 4,
  parameter int TRK_W    = 8,
  parameter int STAT_W   = 8,
  parameter int LOCK_BIT = 4
) (
  input logic             clk,
  input logic             hw_rst,
  input logic             sw_rst,
  input logic             cfg_we,
  input logic             cfg_dis,
  input logic [THR_W-1:0] cfg_thr,
  input logic [TRK_W-1:0] cfg_trk,
  input logic             lock_we,
  input logic             lock_val,
  input logic             fifo_dis,
  input logic [THR_W-1:0] fifo_thr,
  input logic [TRK_W-1:0] pre_trk,
  input logic             lock,
  input logic             stat_vld,
  input logic [STAT_W-1:0] stat_byte
);

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (hw_rst)
    cfg_we |=> (fifo_dis == $past(cfg_dis) && fifo_thr == $past(cfg_thr) && pre_trk == $past(cfg_trk))); // R2
  AST_SW_RESTORE: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && !lock && !cfg_we) |=> (fifo_dis && fifo_thr == '0 && pre_trk == '0)); // R3
  AST_SW_LOCKED_HOLD: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && lock && !cfg_we) |=> ($stable(fifo_dis) && $stable(fifo_thr) && $stable(pre_trk))); // R4
  AST_SW_KEEPS_LOCK: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && !lock_we) |=> $stable(lock)); // R5
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (hw_rst)
    lock_we |=> (lock == $past(lock_val))); // R6
  AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (hw_rst)
    lock_we |=> (stat_vld && stat_byte == (STAT_W'($past(lock_val)) << LOCK_BIT))); // R7
  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (hw_rst)
    !lock_we |=> !stat_vld); // R7

endmodule

bind fifo_cfg_lock fifo_cfg_lock_chk #(
  .THR_W(THR_W), .TRK_W(TRK_W), .STAT_W(STAT_W), .LOCK_BIT(LOCK_BIT)
) u_chk (.*);

// File: tb/fifo_cfg_lock_test.sv
module fifo_cfg_lock_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic       dis;
    logic [3:0] thr;
    logic [7:0] trk;
    logic       lk;
    logic       sv;
    logic [7:0] sb;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       hw_rst = 1'b1;
  logic       sw_rst = 1'b0, cfg_we = 1'b0, cfg_dis = 1'b0, lock_we = 1'b0, lock_val = 1'b0;
  logic [3:0] cfg_thr = '0;
  logic [7:0] cfg_trk = '0;
  logic       fifo_dis, lock, stat_vld;
  logic [3:0] fifo_thr;
  logic [7:0] pre_trk, stat_byte;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  logic       m_dis = 1'b1, m_lk = 1'b0;
  logic [3:0] m_thr = '0;
  logic [7:0] m_trk = '0;

  always #(PERIOD/2) clk = ~clk;

  fifo_cfg_lock uut (
    .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .cfg_we(cfg_we), .cfg_dis(cfg_dis),
    .cfg_thr(cfg_thr), .cfg_trk(cfg_trk), .lock_we(lock_we), .lock_val(lock_val),
    .fifo_dis(fifo_dis), .fifo_thr(fifo_thr), .pre_trk(pre_trk), .lock(lock),
    .stat_vld(stat_vld), .stat_byte(stat_byte)
  );

  task automatic drive(input logic hw, input logic sw, input logic cw, input logic d,
                       input logic [3:0] t, input logic [7:0] k,
                       input logic lw, input logic lv, input string tag);
    exp_t e;
    @(negedge clk);
    hw_rst = hw; sw_rst = sw; cfg_we = cw; cfg_dis = d; cfg_thr = t; cfg_trk = k;
    lock_we = lw; lock_val = lv;
    if (hw) begin
      m_dis = 1'b1; m_thr = '0; m_trk = '0; m_lk = 1'b0;
      e.sv = 1'b0; e.sb = '0;
    end else begin
      if (sw && !m_lk) begin m_dis = 1'b1; m_thr = '0; m_trk = '0; end
      if (cw) begin m_dis = d; m_thr = t; m_trk = k; end
      if (lw) m_lk = lv;
      e.sv = lw;
      e.sb = (q.size() > 0) ? q[$].sb : 8'h00;
      if (lw) e.sb = {3'b000, lv, 4'b0000};
    end
    e.dis = m_dis; e.thr = m_thr; e.trk = m_trk; e.lk = m_lk; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (fifo_dis !== e.dis || fifo_thr !== e.thr || pre_trk !== e.trk ||
          lock !== e.lk || stat_vld !== e.sv || (e.sv && stat_byte !== e.sb) ||
          (e.tag == "R1" && stat_byte !== e.sb)) begin
        n_fail++;
        $display("FAIL %s: got dis=%b thr=%h trk=%h lock=%b vld=%b stat=%h, expected dis=%b thr=%h trk=%h lock=%b vld=%b stat=%h",
                 e.tag, fifo_dis, fifo_thr, pre_trk, lock, stat_vld, stat_byte,
                 e.dis, e.thr, e.trk, e.lk, e.sv, e.sb);
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R1");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R1");
    idle("R1");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 4'h9, 8'h5A, 1'b0, 1'b0, "R2");
    idle("R2");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 4'hC, 8'h33, 1'b0, 1'b0, "R2");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 1'b1, "R6");
    idle("R7");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R4");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R5");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h7, 8'hA1, 1'b0, 1'b0, "R2");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h3, 8'h0F, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0, "R9");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0, "R7");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 4'hE, 8'hC4, 1'b0, 1'b0, "R2");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 1'b1, "R9");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 4'h5, 8'h66, 1'b0, 1'b0, "R2");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 8'hFF, 1'b1, 1'b1, "R10");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, "R10");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 4'h2, 8'h10, 1'b0, 1'b0, "R8");
    idle("R7");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule